// File: doc/BRIEF.md
# Word-Fed Asynchronous Serial Transmitter

This block drains 32-bit words from a first-word-fall-through transmit FIFO and sends them on a single serial line as asynchronous character frames. Each word is split into four bytes, which go out least significant byte first. Every byte becomes one frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits.

The bit period is a whole number of reference clock cycles. That number comes from a programmable divisor that only takes even values between 2 and 32. A software-written run latch starts and stops the block. A single holding register sits between the FIFO and the shifter. The block reports whether it is running and whether the holding register holds a word.

Frame options (parity on or off, parity sense, stop-bit count) and the divisor are captured when a frame starts, so changing them mid-frame does not bend the frame in flight.

Top module: `serial_word_tx`

## Requirements
- R1: After a synchronous reset the line is high, `tx_enabled` is low, `hold_full` is low and `fifo_rd` is low.
- R2: A cycle with `start_wr` high loads `start_val` into the run latch. `tx_enabled` follows on the next cycle, unless a frame is still being sent.
- R3: A frame is a low start bit, then the eight data bits with bit 0 first, then a high stop bit. Each bit lasts exactly N clock cycles. The start bit appears in the cycle after the shifter takes a byte.
- R4: N is `div_sel` with bit 0 cleared. A result of 0 becomes 2 and a result above 32 becomes 32. N is captured at the start of each frame.
- R5: With `par_en` high, one parity bit follows the data bits. `par_odd`=0 selects even parity (the nine bits hold an even number of ones) and `par_odd`=1 selects odd parity.
- R6: With `two_stop` high, the frame ends with two stop bits instead of one.
- R7: When the block is running, the holding register is empty and the FIFO is not empty, `fifo_rd` pulses for one cycle and `hold_full` rises on the next cycle. `hold_full` stays high until the shifter takes the word's fourth byte.
- R8: The bytes of a word go out in the order bits 7:0, 15:8, 23:16, 31:24. Consecutive frames are separated by exactly one idle-high cycle.
- R9: Clearing the run latch mid-frame lets the current byte finish. The line then stays high and the unsent bytes stay in the holding register, and they resume when the latch is set again.
- R10: `tx_enabled` is high exactly when the run latch is set or a frame is in progress.
- R11: `fifo_rd` is never asserted while the run latch is clear, while the holding register is full or while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Write strobe for the run latch |
| start_val | input | 1 | Value written to the run latch |
| div_sel | input | 6 | Raw bit-period divisor |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | 32 | Head word of the transmit FIFO |
| fifo_rd | output | 1 | Pops the FIFO head word |
| tx_line | output | 1 | Serial output, idle high |
| tx_enabled | output | 1 | Running or mid-frame |
| hold_full | output | 1 | Holding register occupied |

## Verification
A corrupted byte index or shift register shows at the line within one bit period of the affected frame, as a wrong data level or as bytes in the wrong order. A divisor counter that miscounts moves the next bit edge, so it shows up within a single bit time. A holding flag that sticks or drops early shows at once, either as a missing or doubled `fifo_rd` pulse or as a `hold_full` level that departs from the reference on the very next cycle. The reference model is compared against all four outputs on every clock, so any divergence is caught on the cycle it first appears.

// File: rtl/swtx_pkg.sv
package swtx_pkg;

    localparam int DEF_DIV_W   = 6;
    localparam int DEF_DIV_MAX = 32;
    localparam int DEF_BYTE_W  = 8;
    localparam int DEF_LANES   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/swtx_baud.sv
module swtx_baud #(
    parameter int DIV_W   = swtx_pkg::DEF_DIV_W,
    parameter int DIV_MAX = swtx_pkg::DEF_DIV_MAX,
    localparam int CNT_W  = $clog2(DIV_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_raw,
    output logic             tick
);
    logic [DIV_W-1:0] even_raw;
    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    // Clear bit 0, then clamp into the legal range 2..DIV_MAX
    always_comb begin
        even_raw = {div_raw[DIV_W-1:1], 1'b0};
        if (even_raw == '0)
            eff = CNT_W'(2);
        else if (even_raw > DIV_W'(DIV_MAX))
            eff = CNT_W'(DIV_MAX);
        else
            eff = CNT_W'(even_raw);
    end

    assign tick = run && (cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            period <= CNT_W'(2);
        end else if (load) begin
            cnt    <= '0;
            period <= eff;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    // R4: the period in use is always even and the counter stays inside it
    p_even_period_r4: assert property (@(posedge clk) disable iff (rst)
        !period[0] && period >= CNT_W'(2));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt < period);

endmodule

// File: rtl/swtx_hold.sv
module swtx_hold #(
    parameter int BYTE_W  = swtx_pkg::DEF_BYTE_W,
    parameter int LANES   = swtx_pkg::DEF_LANES,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              take,
    output logic              fifo_rd,
    output logic              hold_full,
    output logic [BYTE_W-1:0] cur_byte
);
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;
    logic              full;
    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign cur_byte  = lane[idx];
    assign hold_full = full;
    assign fifo_rd   = enable && !full && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            idx  <= '0;
            full <= 1'b0;
        end else if (take) begin
            idx <= idx + 1'b1;
            if (idx == IDX_W'(LANES - 1))
                full <= 1'b0;
        end else if (fifo_rd) begin
            word <= fifo_data;
            idx  <= '0;
            full <= 1'b1;
        end
    end

    // R7: the shifter only takes from a full holder; a read fills it
    p_take_needs_word_r7: assert property (@(posedge clk) disable iff (rst)
        take |-> full);
    p_read_fills_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> full && idx == '0);

endmodule

// File: rtl/swtx_shift.sv
module swtx_shift
    import swtx_pkg::*;
#(
    parameter int BYTE_W = swtx_pkg::DEF_BYTE_W,
    localparam int BIT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_ok,
    input  logic [BYTE_W-1:0] byte_in,
    input  frame_cfg_t        cfg_in,
    input  logic              tick,
    output logic              take,
    output logic              busy,
    output logic              line
);
    tx_state_e         st;
    logic [BYTE_W-1:0] sh;
    logic [BIT_W-1:0]  bitn;
    frame_cfg_t        cfg;
    logic              par;

    assign take = (st == ST_IDLE) && go_ok;
    assign busy = (st != ST_IDLE);

    always_comb begin
        case (st)
            ST_START: line = 1'b0;
            ST_DATA:  line = sh[0];
            ST_PAR:   line = par;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            sh   <= '0;
            bitn <= '0;
            cfg  <= '0;
            par  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (take) begin
                    st   <= ST_START;
                    sh   <= byte_in;
                    cfg  <= cfg_in;
                    par  <= (^byte_in) ^ cfg_in.par_odd;
                    bitn <= '0;
                end
                ST_START: if (tick) st <= ST_DATA;
                ST_DATA: if (tick) begin
                    sh   <= sh >> 1;
                    bitn <= bitn + 1'b1;
                    if (bitn == BIT_W'(BYTE_W - 1))
                        st <= cfg.par_en ? ST_PAR : ST_STOP1;
                end
                ST_PAR:   if (tick) st <= ST_STOP1;
                ST_STOP1: if (tick) st <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2: if (tick) st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // R6: a second stop bit only follows when it was selected at frame start
    p_stop2_cfg_r6: assert property (@(posedge clk) disable iff (rst)
        st == ST_STOP2 |-> cfg.two_stop);

endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx
    import swtx_pkg::*;
#(
    parameter int DIV_W   = swtx_pkg::DEF_DIV_W,
    parameter int DIV_MAX = swtx_pkg::DEF_DIV_MAX,
    parameter int BYTE_W  = swtx_pkg::DEF_BYTE_W,
    parameter int LANES   = swtx_pkg::DEF_LANES,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic              start_val,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic              tx_line,
    output logic              tx_enabled,
    output logic              hold_full
);
    logic              run_en;
    logic              take;
    logic              busy;
    logic              tick;
    logic [BYTE_W-1:0] cur_byte;
    frame_cfg_t        cfg_now;

    always_ff @(posedge clk) begin
        if (rst)
            run_en <= 1'b0;
        else if (start_wr)
            run_en <= start_val;
    end

    assign cfg_now    = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign tx_enabled = run_en || busy;

    swtx_hold #(.BYTE_W(BYTE_W), .LANES(LANES)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .enable     (run_en),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .take       (take),
        .fifo_rd    (fifo_rd),
        .hold_full  (hold_full),
        .cur_byte   (cur_byte)
    );

    swtx_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go_ok   (run_en && hold_full),
        .byte_in (cur_byte),
        .cfg_in  (cfg_now),
        .tick    (tick),
        .take    (take),
        .busy    (busy),
        .line    (tx_line)
    );

    swtx_baud #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .load    (take),
        .run     (busy),
        .div_raw (div_sel),
        .tick    (tick)
    );

    p_enable_write_r2: assert property (@(posedge clk) disable iff (rst)
        start_wr && start_val |=> tx_enabled);
    p_take_then_start_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> !tx_line);
    p_single_read_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !fifo_rd);
    p_stopped_high_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_enabled |-> tx_line);
    p_no_read_stopped_r11: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !fifo_rd);

endmodule

// File: tb/serial_word_tx_tb.sv
module serial_word_tx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_wr = 1'b0;
    logic        start_val = 1'b0;
    logic [5:0]  div_sel = 6'd4;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        two_stop = 1'b0;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_rd;
    logic        tx_line;
    logic        tx_enabled;
    logic        hold_full;

    always #2 clk = ~clk;

    // Bench-side FIFO
    logic [31:0] fmem [64];
    int          fwp = 0;
    int          frp = 0;
    assign fifo_empty = (fwp == frp);
    assign fifo_data  = fifo_empty ? 32'h0 : fmem[frp & 63];

    always @(posedge clk) if (!rst && fifo_rd) frp <= frp + 1;

    serial_word_tx u_dut (
        .clk(clk), .rst(rst), .start_wr(start_wr), .start_val(start_val),
        .div_sel(div_sel), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .tx_line(tx_line), .tx_enabled(tx_enabled), .hold_full(hold_full)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    chk_on = 0;
    string cur_req = "R1";

    // Behavioural reference: per-cycle line levels queued frame by frame
    bit          mq[$];
    bit          m_en;
    bit          m_hv;
    int          m_idx;
    logic [31:0] m_word;

    function automatic int eff_n(input int raw);
        int n;
        n = raw - (raw % 2);
        if (n == 0) n = 2;
        if (n > 32) n = 32;
        return n;
    endfunction

    task automatic push_lvl(input bit lvl, input int n);
        for (int i = 0; i < n; i++) mq.push_back(lvl);
    endtask

    task automatic push_frame(input logic [7:0] b);
        int n;
        n = eff_n(int'(div_sel));
        push_lvl(1'b0, n);
        for (int i = 0; i < 8; i++) push_lvl(b[i], n);
        if (par_en) push_lvl((^b) ^ par_odd, n);
        push_lvl(1'b1, n);
        if (two_stop) push_lvl(1'b1, n);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mq.delete();
            m_en = 0; m_hv = 0; m_idx = 0; m_word = '0;
        end else begin
            bit old_en, old_hv;
            old_en = m_en;
            old_hv = m_hv;
            if (mq.size() > 0) begin
                void'(mq.pop_front());
            end else if (old_en && old_hv) begin
                push_frame(8'(m_word >> (8 * m_idx)));
                if (m_idx == 3) m_hv = 0;
                m_idx++;
            end
            if (old_en && !old_hv && !fifo_empty) begin
                m_hv = 1; m_word = fifo_data; m_idx = 0;
            end
            if (start_wr) m_en = start_val;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary_and_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Per-cycle comparison away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (chk_on) begin
            bit e_line, e_en, e_rd;
            e_line = (mq.size() > 0) ? mq[0] : 1'b1;
            e_en   = m_en || (mq.size() > 0);
            e_rd   = m_en && !m_hv && !fifo_empty;
            check(tx_line == e_line, cur_req, "tx_line (R3)", int'(tx_line), int'(e_line));
            check(tx_enabled == e_en, cur_req, "tx_enabled (R10)", int'(tx_enabled), int'(e_en));
            check(hold_full == m_hv, cur_req, "hold_full (R7)", int'(hold_full), int'(m_hv));
            check(fifo_rd == e_rd, cur_req, "fifo_rd (R11)", int'(fifo_rd), int'(e_rd));
        end
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
            summary_and_end();
        end
    end

    task automatic set_cfg(input int d, input bit pe, input bit po, input bit ts);
        @(negedge clk);
        div_sel = 6'(d); par_en = pe; par_odd = po; two_stop = ts;
    endtask

    task automatic write_start(input bit v);
        @(negedge clk);
        start_wr = 1'b1; start_val = v;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        fmem[fwp & 63] = w;
        fwp++;
    endtask

    task automatic drain();
        int k = 0;
        @(negedge clk);
        while (!(mq.size() == 0 && !m_hv && fwp == frp) && k < 20000) begin
            @(negedge clk);
            k++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(tx_line == 1'b1, "R1", "reset tx_line", int'(tx_line), 1);
        check(tx_enabled == 1'b0, "R1", "reset tx_enabled", int'(tx_enabled), 0);
        check(hold_full == 1'b0, "R1", "reset hold_full", int'(hold_full), 0);
        check(fifo_rd == 1'b0, "R1", "reset fifo_rd", int'(fifo_rd), 0);
        chk_on = 1;

        // R2: run latch write shows on tx_enabled the next cycle
        cur_req = "R2";
        write_start(1'b1);
        #1;
        check(tx_enabled == 1'b1, "R2", "enabled after start write", int'(tx_enabled), 1);

        // R11: running with an empty FIFO reads nothing
        cur_req = "R11";
        repeat (10) @(negedge clk);

        // R3: plain frames
        cur_req = "R3";
        set_cfg(4, 0, 0, 0);
        push_word(32'hA5C3_0F81);
        drain();

        // R5: even then odd parity
        cur_req = "R5";
        set_cfg(6, 1, 0, 0);
        push_word(32'h7E01_FF00);
        drain();
        set_cfg(6, 1, 1, 0);
        push_word(32'h3C96_5A13);
        drain();

        // R6: two stop bits, with and without parity
        cur_req = "R6";
        set_cfg(2, 0, 0, 1);
        push_word(32'h0123_4567);
        drain();
        set_cfg(4, 1, 1, 1);
        push_word(32'h89AB_CDEF);
        drain();

        // R4: divisor rounding and clamping
        cur_req = "R4";
        set_cfg(0, 0, 0, 0);
        push_word(32'h55AA_55AA);
        drain();
        set_cfg(7, 0, 0, 0);
        push_word(32'h1248_8421);
        drain();
        set_cfg(63, 0, 0, 0);
        push_word(32'hF00F_C33C);
        drain();
        set_cfg(33, 1, 0, 0);
        push_word(32'h0000_0001);
        drain();

        // R8: several words back to back
        cur_req = "R8";
        set_cfg(2, 0, 0, 0);
        push_word(32'h4433_2211);
        push_word(32'h8877_6655);
        push_word(32'hCCBB_AA99);
        drain();

        // R9: stop mid-frame, byte finishes, rest waits in holder
        cur_req = "R9";
        set_cfg(8, 0, 0, 0);
        push_word(32'hDEAD_BEEF);
        repeat (40) @(negedge clk);
        write_start(1'b0);
        repeat (200) @(negedge clk);
        #1;
        check(tx_line == 1'b1, "R9", "line after stop", int'(tx_line), 1);
        check(tx_enabled == 1'b0, "R9", "enabled after stop", int'(tx_enabled), 0);
        check(hold_full == 1'b1, "R9", "holder keeps word", int'(hold_full), 1);
        write_start(1'b1);
        drain();

        // R2: clearing the latch while idle drops tx_enabled next cycle
        cur_req = "R2";
        write_start(1'b0);
        #1;
        check(tx_enabled == 1'b0, "R2", "enabled after stop write", int'(tx_enabled), 0);

        // R11: words pending while stopped are not read
        cur_req = "R11";
        push_word(32'h1111_2222);
        repeat (20) @(negedge clk);
        #1;
        check(fifo_rd == 1'b0, "R11", "no read while stopped", int'(fifo_rd), 0);
        write_start(1'b1);
        drain();

        chk_on = 0;
        summary_and_end();
    end

endmodule